// File: doc/BRIEF.md
# Mixed-Latency Byte Arithmetic Unit

This unit combines two 8-bit unsigned operands under a 3-bit operation code and returns a 16-bit result. It supports sum, bitwise AND, bitwise XOR and full product. A requester drives the operands and the code, raises `start` and keeps everything steady until it sees `done`. It then lowers `start`. Sum, AND and XOR complete one cycle after acceptance. The product runs through a registered multiplier pipeline and completes later. The idle code and the unused codes are accepted but never complete. `done` is a single-cycle pulse.

The result register holds its value between completions. A synchronous active-low reset clears it to zero. The same reset also cancels a product that is still in flight. Once an operation has been accepted, the unit takes no new one until it has seen `start` low, so a requester that holds `start` high for several cycles gets exactly one completion.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result` becomes 0 and `done` becomes 0; holding it low for two cycles fully initialises the unit.
- R2: Code 3'b001 (sum) gives `result` = A + B with the carry in bit 8 and bits 15:9 zero.
- R3: Code 3'b010 (AND) gives `result` = {8'h00, A & B}.
- R4: Code 3'b011 (XOR) gives `result` = {8'h00, A ^ B}.
- R5: For sum, AND and XOR, `done` is high in the first cycle after the edge that accepts `start`, and `result` is valid in that same cycle.
- R6: Code 3'b100 (product) gives the full 16-bit A * B. `done` is low in the first two cycles after acceptance and high in the third.
- R7: `done` is high for exactly one cycle per completed operation. Holding `start` high after completion produces no further `done`, and `result` does not change.
- R8: Codes 3'b000, 3'b101, 3'b110 and 3'b111 produce no `done` and leave `result` unchanged.
- R9: Operands and code are captured at acceptance. Changing them while a product is in flight does not change the product delivered.
- R10: A reset while a product is in flight cancels it. No `done` follows, and `result` reads 0.
- R11: Back-to-back operations of any mix are each accepted and complete with correct results, provided `start` is low for at least one cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request; held high until `done` is seen |
| op | input | 3 | Operation code |
| a | input | 8 | First operand, unsigned |
| b | input | 8 | Second operand, unsigned |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Last completed result, zero-extended |

## Verification
The hardest cases to reach from the ports are those that arise while a product is in flight. One is a request whose operands and code change under it. The other is a reset that arrives before completion. The stimulus raises `start` for a product and waits one cycle. It then either replaces the operands and code with different values, or pulls `rst_n` low for two cycles and lowers `start` while reset is held. A follow-up operation shows that the unit recovers. The one-completion-per-request rule is exercised by keeping `start` high for several cycles after `done`.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPCODE_W = 3;

  typedef enum logic [OPCODE_W-1:0] {
    OPC_IDLE = 3'b000,
    OPC_SUM  = 3'b001,
    OPC_CONJ = 3'b010,
    OPC_DIFF = 3'b011,
    OPC_PROD = 3'b100,
    OPC_RSV5 = 3'b101,
    OPC_RSV6 = 3'b110,
    OPC_CLR  = 3'b111
  } opc_e;

  typedef enum logic [1:0] {
    CLS_NULL = 2'd0,
    CLS_FAST = 2'd1,
    CLS_MUL  = 2'd2
  } opcls_e;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [OPCODE_W-1:0] op,
  output opcls_e              cls
);
  always_comb begin
    case (op)
      OPC_SUM, OPC_CONJ, OPC_DIFF: cls = CLS_FAST;
      OPC_PROD:                    cls = CLS_MUL;
      default:                     cls = CLS_NULL;
    endcase
  end
endmodule

// File: rtl/alu_fast_path.sv
module alu_fast_path
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RES_W = 2 * DATA_W
) (
  input  logic [OPCODE_W-1:0] op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [RES_W-1:0]    y
);
  function automatic logic [RES_W-1:0] f_sum(logic [DATA_W-1:0] x, logic [DATA_W-1:0] z);
    logic [DATA_W:0] s;
    s = {1'b0, x} + {1'b0, z};
    return {{(DATA_W-1){1'b0}}, s};
  endfunction

  function automatic logic [RES_W-1:0] f_conj(logic [DATA_W-1:0] x, logic [DATA_W-1:0] z);
    return {{DATA_W{1'b0}}, x & z};
  endfunction

  function automatic logic [RES_W-1:0] f_diff(logic [DATA_W-1:0] x, logic [DATA_W-1:0] z);
    return {{DATA_W{1'b0}}, x ^ z};
  endfunction

  always_comb begin
    case (op)
      OPC_SUM:  y = f_sum(a, b);
      OPC_CONJ: y = f_conj(a, b);
      OPC_DIFF: y = f_diff(a, b);
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu_mul_pipe.sv
module alu_mul_pipe #(
  parameter int DATA_W = 8,
  parameter int STAGES = 3,
  localparam int RES_W = 2 * DATA_W,
  localparam int MID   = STAGES - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              busy,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_prod
);
  function automatic logic [RES_W-1:0] f_prod(logic [DATA_W-1:0] x, logic [DATA_W-1:0] z);
    logic [RES_W-1:0] xe;
    logic [RES_W-1:0] ze;
    xe = {{DATA_W{1'b0}}, x};
    ze = {{DATA_W{1'b0}}, z};
    return xe * ze;
  endfunction

  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic              v0_q;
  logic [RES_W-1:0]  prod_c;
  logic [MID-1:0]    v_q;
  logic [RES_W-1:0]  p_q [MID];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      v0_q <= launch;
      if (launch) begin
        a_q <= a;
        b_q <= b;
      end
    end
  end

  assign prod_c = f_prod(a_q, b_q);

  for (genvar g = 0; g < MID; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          p_q[g] <= '0;
        end else begin
          v_q[g] <= v0_q;
          if (v0_q) p_q[g] <= prod_c;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          p_q[g] <= '0;
        end else begin
          v_q[g] <= v_q[g-1];
          if (v_q[g-1]) p_q[g] <= p_q[g-1];
        end
      end
    end
  end

  assign out_valid = v_q[MID-1];
  assign out_prod  = p_q[MID-1];
  assign busy      = v0_q | (|v_q);
endmodule

// File: rtl/alu_handshake.sv
module alu_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic accept
);
  logic armed_q;

  assign accept = start && armed_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b1;
    else if (accept) armed_q <= 1'b0;
    else if (!start) armed_q <= 1'b1;
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import alu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MUL_STAGES = 3,
  localparam int RES_W     = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OPCODE_W-1:0] op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic                done,
  output logic [RES_W-1:0]    result
);
  opcls_e           cls;
  logic             accept;
  logic             mul_busy;
  logic             mul_out_valid;
  logic [RES_W-1:0] mul_prod;
  logic [RES_W-1:0] fast_y;
  logic             acc_fast;
  logic             acc_mul;
  logic             acc_null;

  alu_op_decode u_dec (.op(op), .cls(cls));

  alu_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(mul_busy), .accept(accept)
  );

  alu_fast_path #(.DATA_W(DATA_W)) u_fast (
    .op(op), .a(a), .b(b), .y(fast_y)
  );

  assign acc_fast = accept && (cls == CLS_FAST);
  assign acc_mul  = accept && (cls == CLS_MUL);
  assign acc_null = accept && (cls == CLS_NULL);

  alu_mul_pipe #(.DATA_W(DATA_W), .STAGES(MUL_STAGES)) u_mul (
    .clk(clk), .rst_n(rst_n), .launch(acc_mul), .a(a), .b(b),
    .busy(mul_busy), .out_valid(mul_out_valid), .out_prod(mul_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= acc_fast | mul_out_valid;
      if (acc_fast)           result <= fast_y;
      else if (mul_out_valid) result <= mul_prod;
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic             acc_fast,
  input logic             acc_mul,
  input logic             acc_null
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (result == '0 && !done)); // R1
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n) acc_fast |=> done); // R5
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) acc_mul |=> !done ##1 !done ##1 done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_NULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) acc_null |=> !done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R8
endmodule

bind byte_alu byte_alu_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .result(result),
  .acc_fast(acc_fast), .acc_mul(acc_mul), .acc_null(acc_null)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [7:0]  a = 8'h00;
  logic [7:0]  b = 8'h00;
  logic        done;
  logic [15:0] result;

  int errors = 0;
  int checks = 0;

  byte_alu u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
               .done(done), .result(result));

  always #4 clk = ~clk;

  // {op, a, b, expected}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {3'b001, 8'hFF, 8'hFF, 16'h01FE},
    {3'b001, 8'h00, 8'h00, 16'h0000},
    {3'b001, 8'h80, 8'h80, 16'h0100},
    {3'b001, 8'h7F, 8'h01, 16'h0080},
    {3'b010, 8'hF0, 8'h3C, 16'h0030},
    {3'b010, 8'hFF, 8'hFF, 16'h00FF},
    {3'b011, 8'hAA, 8'h55, 16'h00FF},
    {3'b011, 8'hFF, 8'hFF, 16'h0000},
    {3'b100, 8'hFF, 8'hFF, 16'hFE01},
    {3'b100, 8'h00, 8'hFF, 16'h0000},
    {3'b100, 8'h12, 8'h34, 16'h03A8},
    {3'b100, 8'h10, 8'h10, 16'h0100},
    {3'b010, 8'h0F, 8'hF3, 16'h0003}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Full request: returns result at done and cycles from acceptance to done.
  task automatic run_op(input logic [2:0] o, input logic [7:0] x, input logic [7:0] z,
                        output logic [15:0] got, output int lat);
    @(negedge clk);
    op = o; a = x; b = z; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 10);
    got = result;
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] got;
    logic [15:0] prev;
    int lat;
    int seen;

    do_reset();
    @(negedge clk);
    check("R1 reset result", result, 0);
    check("R1 reset done", done, 0);

    // table walk: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vo;
      vo = VEC[i][34:32];
      run_op(vo, VEC[i][31:24], VEC[i][23:16], got, lat);
      check(vo == 3'b001 ? "R2 sum" : vo == 3'b010 ? "R3 and" :
            vo == 3'b011 ? "R4 xor" : "R6 product", got, VEC[i][15:0]);
      check(vo == 3'b100 ? "R6 latency" : "R5 latency", lat, vo == 3'b100 ? 3 : 1);
      check("R7 pulse low after drop", done, 0);
    end

    // R7: start held after completion
    @(negedge clk);
    op = 3'b001; a = 8'h21; b = 8'h12; start = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R7 single done while held", seen, 1);
    check("R7 result while held", result, 16'h0033);
    start = 1'b0;
    @(negedge clk);

    // R8: idle and unused codes
    prev = result;
    for (int c = 0; c < 4; c++) begin
      logic [2:0] nc;
      nc = (c == 0) ? 3'b000 : 3'(4 + c);
      @(negedge clk);
      op = nc; a = 8'h5A; b = 8'hC3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = done ? 1 : 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check("R8 no done for null code", seen, 0);
      check("R8 result unchanged", result, prev);
    end

    // R9: operands change under a product
    @(negedge clk);
    op = 3'b100; a = 8'h03; b = 8'h05; start = 1'b1;
    @(negedge clk);
    op = 3'b001; a = 8'hFF; b = 8'hFF;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check("R9 captured product", result, 16'h000F);
    check("R9 latency", lat, 3);
    start = 1'b0;
    @(negedge clk);

    // R10: reset mid-product
    run_op(3'b011, 8'hA5, 8'h0F, got, lat);
    check("R10 setup result", got, 16'h00AA);
    @(negedge clk);
    op = 3'b100; a = 8'hFF; b = 8'hFE; start = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R10 no done after cancel", seen, 0);
    check("R10 result cleared", result, 0);

    // R11: recovery and back-to-back mix
    run_op(3'b100, 8'h0B, 8'h0D, got, lat);
    check("R11 product after reset", got, 16'h008F);
    run_op(3'b100, 8'h80, 8'h02, got, lat);
    check("R11 repeated product", got, 16'h0100);
    run_op(3'b001, 8'h01, 8'hFF, got, lat);
    check("R11 sum after product", got, 16'h0100);
    check("R11 sum latency", lat, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule